// File: doc/BRIEF.md
# DDR2 Read Burst Output Sequencer

This block models the device side of a double-data-rate read. Each accepted read command carries a bank, a starting column, a burst-length select (4 or 8 beats) and an auto-precharge flag. The block waits a programmable read latency and then plays the burst out as one rising-edge/falling-edge data pair per clock, with a per-cycle output enable. It also drives a strobe with its own enable, including a preamble cycle and a postamble cycle. The read latency is the sum of an additive latency and a CAS latency. Each of the two is programmed separately, clamped to its supported range, and reported when out of range.

The data is generated internally from the bank, the wrapped column and the beat index, so a bench can predict every word without a memory array. Back-to-back reads at the right spacing merge into one continuous data and strobe stream. An 8-beat burst without auto precharge may be cut short by a following read, but only after its first four beats. A read that would break these spacing rules is ignored. At the end of each burst, a one-cycle pulse reports the bank and whether the row was precharged or left open. The strobe complement is the inversion of the strobe at the pad and is not a separate output.

Top module: `ddr2rd_seq`

## Requirements
- R1: With no overlapping burst, the first data pair of a read sampled at clock edge k is on the outputs right after edge k+RL. RL is the clamped additive latency plus the clamped CAS latency.
- R2: Additive latency above 4 is taken as 4. CAS latency below 3 is taken as 3, and above 6 is taken as 6. `cfg_err` is high exactly when either raw setting is outside its range.
- R3: Each data cycle carries beats 2p (on `dq_rise`) and 2p+1 (on `dq_fall`). A data word is {bank[2:0], column[9:0], beat[2:0]}, MSB first. The column of beat i wraps within the aligned 4- or 8-column block that holds the start column (sequential order).
- R4: `dqs_oe` is high and `dqs_hi` is high in every data cycle. In the cycle before the first data cycle of a stream, `dqs_oe` is high and `dqs_hi` is low (preamble).
- R5: In the cycle after the last data cycle of a stream, `dqs_oe` is high with `dqs_hi` low (postamble). Outside data cycles, `dq_oe` is low and both data outputs are zero.
- R6: A read sampled 2 cycles after a 4-beat read, or 4 cycles after an 8-beat read, continues the data with no idle cycle, no preamble and no postamble between the two bursts.
- R7: A read sampled 1 cycle after any accepted read is ignored. A 4-beat burst always completes.
- R8: A read sampled 2 cycles after an 8-beat read with auto precharge clear truncates that burst after beat 3, and its own data follows directly. Reads at 3 cycles after it, or at 2 or 3 cycles after an 8-beat read with auto precharge set, are ignored.
- R9: `burst_end` pulses for one cycle right after the last data cycle of each burst, with `end_bank` set. `end_precharged` is 1 only if the burst had auto precharge and ran all its beats; otherwise it is 0 and the row is open.
- R10: While reset is asserted, all data, strobe, enable and end outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al | input | 3 | Additive latency setting |
| cfg_cl | input | 3 | CAS latency setting |
| cmd_rd | input | 1 | Read command valid for this cycle |
| cmd_bank | input | 3 | Bank of the read |
| cmd_col | input | 10 | Starting column of the read |
| cmd_ap | input | 1 | Auto precharge at end of burst |
| cmd_bl8 | input | 1 | 1: 8-beat burst, 0: 4-beat burst |
| cfg_err | output | 1 | A latency setting is out of range |
| dq_rise | output | 16 | Data word for the rising half of the cycle |
| dq_fall | output | 16 | Data word for the falling half of the cycle |
| dq_oe | output | 1 | Data drive enable |
| dqs_hi | output | 1 | Strobe level in the first half of the cycle (second half is low) |
| dqs_oe | output | 1 | Strobe drive enable |
| burst_end | output | 1 | One-cycle pulse at burst completion |
| end_bank | output | 3 | Bank of the completed burst |
| end_precharged | output | 1 | 1: row precharged, 0: row left open |

## Verification
The bench builds the block with its default widths: 8 banks and 10 column bits. Latency settings span the full 3-bit range, so clamping at both ends and the longest read latency of 10 cycles come into play. It also covers every spacing between reads from 1 to 5 cycles. Those spacings expose gapless chaining, truncation at the 4-beat point, rejected reads and the shared preamble/postamble cycle, each under random bursts and as directed cases.

// File: rtl/ddr2rd_pkg.sv
package ddr2rd_pkg;

  // Supported latency window
  localparam int unsigned AL_MAX = 4;
  localparam int unsigned CL_MIN = 3;
  localparam int unsigned CL_MAX = 6;
  localparam int unsigned RL_MAX = AL_MAX + CL_MAX;

  // Spacing rules between accepted reads (in clocks)
  localparam int unsigned GAP_SHORT = 2;   // BL4 chaining, BL8 truncation point
  localparam int unsigned GAP_LONG  = 4;   // BL8 chaining

  typedef struct packed {
    logic bl8;
    logic ap;
  } rd_kind_t;

  // Low three column bits of beat `beat` for a burst starting at `start_lo`
  function automatic logic [2:0] beat_col_lo(input logic [2:0] start_lo,
                                             input logic [2:0] beat,
                                             input logic       bl8);
    logic [2:0] sum;
    sum = start_lo + beat;
    return bl8 ? sum : {start_lo[2], sum[1:0]};
  endfunction

endpackage

// File: rtl/ddr2rd_latency.sv
module ddr2rd_latency
  import ddr2rd_pkg::*;
#(
  parameter int unsigned AL_W = 3,
  parameter int unsigned CL_W = 3,
  parameter int unsigned RL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AL_W-1:0] al_i,
  input  logic [CL_W-1:0] cl_i,
  output logic [RL_W-1:0] rl_o,
  output logic            err_o
);

  logic            al_big, cl_low, cl_big;
  logic [RL_W-1:0] al_c, cl_c;

  always_comb begin
    al_big = int'(al_i) > int'(AL_MAX);
    cl_low = int'(cl_i) < int'(CL_MIN);
    cl_big = int'(cl_i) > int'(CL_MAX);
    al_c   = al_big ? RL_W'(AL_MAX) : RL_W'(al_i);
    cl_c   = cl_low ? RL_W'(CL_MIN) : (cl_big ? RL_W'(CL_MAX) : RL_W'(cl_i));
    rl_o   = al_c + cl_c;
    err_o  = al_big | cl_low | cl_big;
  end

  // R2
  rl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rl_o >= RL_W'(CL_MIN)) && (rl_o <= RL_W'(RL_MAX)));

endmodule

// File: rtl/ddr2rd_admit.sv
module ddr2rd_admit
  import ddr2rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic bl8_i,
  input  logic ap_i,
  output logic acc_o
);

  localparam int unsigned CNT_W = $clog2(GAP_LONG + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  rd_kind_t         kind_q, kind_n;
  logic             gap_ok;

  always_comb begin
    gap_ok = (cnt_q >= CNT_W'(GAP_LONG))
           || ((cnt_q >= CNT_W'(GAP_SHORT)) && !kind_q.bl8)
           || ((cnt_q == CNT_W'(GAP_SHORT)) && kind_q.bl8 && !kind_q.ap);
    acc_o  = rd_i && gap_ok;
    if (acc_o)
      cnt_n = CNT_W'(1);
    else if (cnt_q < CNT_W'(GAP_LONG))
      cnt_n = cnt_q + CNT_W'(1);
    else
      cnt_n = cnt_q;
    kind_n = '{bl8: bl8_i, ap: ap_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(GAP_LONG);
      kind_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (acc_o) kind_q <= kind_n;
    end
  end

  // R7
  no_adjacent_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |=> !acc_o);

endmodule

// File: rtl/ddr2rd_delay.sv
module ddr2rd_delay #(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned RL_W   = 4,
  parameter int unsigned DESC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [RL_W-1:0]   rl_i,
  output logic              head_v_o,
  output logic [DESC_W-1:0] head_d_o,
  output logic              soon_v_o
);

  logic [RL_W-1:0]   ins;
  logic [DEPTH-1:0]  v_q;
  logic [DESC_W-1:0] d_q [DEPTH];
  logic [DEPTH-1:0]  v_sh;
  logic              next_busy;

  assign ins = rl_i - RL_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              hit;
    logic              v_r, v_n;
    logic [DESC_W-1:0] d_r, d_n;

    assign hit = acc_i && (ins == RL_W'(i));

    if (i == DEPTH - 1) begin : g_tail
      assign v_n = hit;
      assign d_n = hit ? desc_i : '0;
    end else begin : g_body
      assign v_n = hit | v_q[i+1];
      assign d_n = hit ? desc_i : d_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
        d_r <= '0;
      end else begin
        v_r <= v_n;
        d_r <= d_n;
      end
    end

    assign v_q[i] = v_r;
    assign d_q[i] = d_r;
  end

  assign v_sh      = v_q >> ins;
  assign next_busy = v_sh[1];

  assign head_v_o = v_q[0];
  assign head_d_o = d_q[0];
  assign soon_v_o = v_q[1];

  // R6
  slot_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> !next_busy);

endmodule

// File: rtl/ddr2rd_burst.sv
module ddr2rd_burst
  import ddr2rd_pkg::*;
#(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned DQ_W   = BANK_W + COL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_v_i,
  input  logic [BANK_W-1:0] head_bank_i,
  input  logic [COL_W-1:0]  head_col_i,
  input  logic              head_bl8_i,
  input  logic              head_ap_i,
  input  logic              soon_v_i,
  output logic [DQ_W-1:0]   dq_rise_o,
  output logic [DQ_W-1:0]   dq_fall_o,
  output logic              dq_oe_o,
  output logic              dqs_hi_o,
  output logic              dqs_oe_o,
  output logic              end_v_o,
  output logic [BANK_W-1:0] end_bank_o,
  output logic              end_pre_o
);

  logic              act_q, act_n;
  logic [1:0]        pair_q, pair_n;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              bl8_q, ap_q;
  logic              pre_q, pre_n, pst_q, pst_n;
  logic              end_q, end_n, end_pre_q, end_pre_n;
  logic [BANK_W-1:0] end_bank_q;
  logic [1:0]        last;
  logic              at_last, cont;
  logic [2:0]        lo_r, lo_f;

  // Next-state logic
  always_comb begin
    last    = bl8_q ? 2'd3 : 2'd1;
    at_last = act_q && (pair_q == last);
    cont    = act_q && !at_last;
    act_n   = head_v_i | cont;
    if (head_v_i)
      pair_n = 2'd0;
    else if (cont)
      pair_n = pair_q + 2'd1;
    else
      pair_n = pair_q;
    end_n     = act_q && (at_last || head_v_i);
    end_pre_n = ap_q && at_last;
    pst_n     = at_last && !head_v_i;
    pre_n     = soon_v_i && !act_n;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      pair_q     <= 2'd0;
      bank_q     <= '0;
      col_q      <= '0;
      bl8_q      <= 1'b0;
      ap_q       <= 1'b0;
      pre_q      <= 1'b0;
      pst_q      <= 1'b0;
      end_q      <= 1'b0;
      end_pre_q  <= 1'b0;
      end_bank_q <= '0;
    end else begin
      act_q     <= act_n;
      pair_q    <= pair_n;
      pre_q     <= pre_n;
      pst_q     <= pst_n;
      end_q     <= end_n;
      end_pre_q <= end_pre_n;
      if (head_v_i) begin
        bank_q <= head_bank_i;
        col_q  <= head_col_i;
        bl8_q  <= head_bl8_i;
        ap_q   <= head_ap_i;
      end
      if (end_n) end_bank_q <= bank_q;
    end
  end

  // Output decode
  always_comb begin
    lo_r = beat_col_lo(col_q[2:0], {pair_q, 1'b0}, bl8_q);
    lo_f = beat_col_lo(col_q[2:0], {pair_q, 1'b1}, bl8_q);
    dq_rise_o = act_q ? {bank_q, col_q[COL_W-1:3], lo_r, pair_q, 1'b0} : '0;
    dq_fall_o = act_q ? {bank_q, col_q[COL_W-1:3], lo_f, pair_q, 1'b1} : '0;
    dq_oe_o   = act_q;
    dqs_hi_o  = act_q;
    dqs_oe_o  = act_q | pre_q | pst_q;
  end

  assign end_v_o    = end_q;
  assign end_bank_o = end_bank_q;
  assign end_pre_o  = end_pre_q;

  // R8
  takeover_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_v_i && act_q) |-> (at_last || (bl8_q && !ap_q && (pair_q == 2'd1))));

  // R3
  pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (pair_q <= last));

  // R4
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe_o) |-> $past(dqs_oe_o));

  // R5
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe_o) |-> (dqs_oe_o && !dqs_hi_o));

  // R9
  end_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_v_o |-> $past(dq_oe_o));

endmodule

// File: rtl/ddr2rd_seq.sv
module ddr2rd_seq
  import ddr2rd_pkg::*;
#(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AL_W   = 3,
  parameter int unsigned CL_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AL_W-1:0]            cfg_al,
  input  logic [CL_W-1:0]            cfg_cl,
  input  logic                       cmd_rd,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [COL_W-1:0]           cmd_col,
  input  logic                       cmd_ap,
  input  logic                       cmd_bl8,
  output logic                       cfg_err,
  output logic [BANK_W+COL_W+2:0]    dq_rise,
  output logic [BANK_W+COL_W+2:0]    dq_fall,
  output logic                       dq_oe,
  output logic                       dqs_hi,
  output logic                       dqs_oe,
  output logic                       burst_end,
  output logic [BANK_W-1:0]          end_bank,
  output logic                       end_precharged
);

  localparam int unsigned DQ_W   = BANK_W + COL_W + 3;
  localparam int unsigned DEPTH  = RL_MAX;
  localparam int unsigned RL_W   = $clog2(RL_MAX + 1);
  localparam int unsigned DESC_W = BANK_W + COL_W + 2;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic [RL_W-1:0]   rl;
  logic              acc;
  logic              head_v, soon_v;
  logic [DESC_W-1:0] head_d;

  ddr2rd_latency #(.AL_W(AL_W), .CL_W(CL_W), .RL_W(RL_W)) u_lat (
    .clk   (clk),
    .rst_n (srst_n),
    .al_i  (cfg_al),
    .cl_i  (cfg_cl),
    .rl_o  (rl),
    .err_o (cfg_err)
  );

  ddr2rd_admit u_admit (
    .clk   (clk),
    .rst_n (srst_n),
    .rd_i  (cmd_rd),
    .bl8_i (cmd_bl8),
    .ap_i  (cmd_ap),
    .acc_o (acc)
  );

  ddr2rd_delay #(.DEPTH(DEPTH), .RL_W(RL_W), .DESC_W(DESC_W)) u_dly (
    .clk      (clk),
    .rst_n    (srst_n),
    .acc_i    (acc),
    .desc_i   ({cmd_bank, cmd_col, cmd_bl8, cmd_ap}),
    .rl_i     (rl),
    .head_v_o (head_v),
    .head_d_o (head_d),
    .soon_v_o (soon_v)
  );

  ddr2rd_burst #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_burst (
    .clk         (clk),
    .rst_n       (srst_n),
    .head_v_i    (head_v),
    .head_bank_i (head_d[DESC_W-1 -: BANK_W]),
    .head_col_i  (head_d[COL_W+1:2]),
    .head_bl8_i  (head_d[1]),
    .head_ap_i   (head_d[0]),
    .soon_v_i    (soon_v),
    .dq_rise_o   (dq_rise),
    .dq_fall_o   (dq_fall),
    .dq_oe_o     (dq_oe),
    .dqs_hi_o    (dqs_hi),
    .dqs_oe_o    (dqs_oe),
    .end_v_o     (burst_end),
    .end_bank_o  (end_bank),
    .end_pre_o   (end_precharged)
  );

endmodule

// File: tb/ddr2rd_seq_test.sv
`timescale 1ns/1ps
module ddr2rd_seq_test;

  localparam int SEG  = 80;
  localparam int MAXC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_al, cfg_cl;
  logic        cmd_rd, cmd_ap, cmd_bl8;
  logic [2:0]  cmd_bank;
  logic [9:0]  cmd_col;
  logic        cfg_err, dq_oe, dqs_hi, dqs_oe, burst_end, end_precharged;
  logic [15:0] dq_rise, dq_fall;
  logic [2:0]  end_bank;

  always #2.5 clk = ~clk;

  ddr2rd_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
    .cmd_rd(cmd_rd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .cmd_bl8(cmd_bl8), .cfg_err(cfg_err),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .dqs_hi(dqs_hi), .dqs_oe(dqs_oe), .burst_end(burst_end),
    .end_bank(end_bank), .end_precharged(end_precharged)
  );

  int nchk = 0;
  int nerr = 0;

  int ncmd;
  int c_k[MAXC], c_bank[MAXC], c_col[MAXC], c_ap[MAXC], c_bl8[MAXC];

  logic        e_oe[SEG];
  logic [15:0] e_r[SEG], e_f[SEG];
  logic        e_end[SEG], e_ep[SEG];
  logic [2:0]  e_eb[SEG];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // R3 data word: {bank, wrapped column, beat}
  function automatic logic [15:0] word(int bank, int col, int beat, bit bl8);
    int lo;
    lo = bl8 ? ((col + beat) & 7) : ((col & 4) | ((col + beat) & 3));
    return {3'(bank), 10'((col & ~7) | lo), 3'(beat)};
  endfunction

  task automatic add_cmd(input int k, input int bank, input int col,
                         input int ap, input int bl8);
    c_k[ncmd] = k; c_bank[ncmd] = bank; c_col[ncmd] = col;
    c_ap[ncmd] = ap; c_bl8[ncmd] = bl8;
    ncmd++;
  endtask

  // Expected schedule from R1, R6, R7, R8, R9
  task automatic build_model(input int rl);
    int a_s[MAXC], a_b[MAXC], a_c[MAXC], a_ap[MAXC], a_l[MAXC];
    int na, last_k, last_bl8, last_ap, gap;
    bit ok;
    na = 0; last_k = -100; last_bl8 = 0; last_ap = 0;
    for (int t = 0; t < SEG; t++) begin
      e_oe[t] = 0; e_r[t] = '0; e_f[t] = '0;
      e_end[t] = 0; e_ep[t] = 0; e_eb[t] = '0;
    end
    for (int i = 0; i < ncmd; i++) begin
      gap = c_k[i] - last_k;
      ok = (gap >= 4) || (gap >= 2 && last_bl8 == 0) ||
           (gap == 2 && last_bl8 == 1 && last_ap == 0);
      if (ok) begin
        a_s[na] = c_k[i] + rl; a_b[na] = c_bank[i]; a_c[na] = c_col[i];
        a_ap[na] = c_ap[i]; a_l[na] = c_bl8[i];
        na++;
        last_k = c_k[i]; last_bl8 = c_bl8[i]; last_ap = c_ap[i];
      end
    end
    for (int j = 0; j < na; j++) begin
      int full, len;
      full = a_l[j] ? 4 : 2;
      len = full;
      if (j + 1 < na && a_s[j+1] - a_s[j] < full) len = a_s[j+1] - a_s[j];
      for (int p = 0; p < len; p++) begin
        e_oe[a_s[j]+p] = 1;
        e_r[a_s[j]+p]  = word(a_b[j], a_c[j], 2*p, a_l[j] != 0);
        e_f[a_s[j]+p]  = word(a_b[j], a_c[j], 2*p+1, a_l[j] != 0);
      end
      e_end[a_s[j]+len] = 1;
      e_eb[a_s[j]+len]  = 3'(a_b[j]);
      e_ep[a_s[j]+len]  = (a_ap[j] != 0) && (len == full);
    end
  endtask

  task automatic run_seg(input int al, input int cl, input string tag);
    int eal, ecl, rl;
    bit eerr;
    eal  = (al > 4) ? 4 : al;
    ecl  = (cl < 3) ? 3 : ((cl > 6) ? 6 : cl);
    eerr = (al > 4) || (cl < 3) || (cl > 6);
    rl   = eal + ecl;
    @(negedge clk);
    cfg_al = 3'(al); cfg_cl = 3'(cl);
    #1;
    chk(cfg_err == eerr, "R2", {tag, " cfg_err"}, 32'(cfg_err), 32'(eerr));
    build_model(rl);
    for (int t = 0; t < SEG; t++) begin
      @(negedge clk);
      if (t > 0) begin
        int s;
        logic xoe;
        s = t - 1;
        xoe = e_oe[s] | ((s + 1 < SEG) && e_oe[s+1]) | ((s > 0) && e_oe[s-1]);
        // R1 R3 R5 R6 R7 R8: data and its enable
        chk(dq_oe == e_oe[s] && dq_rise == e_r[s] && dq_fall == e_f[s],
            "R1 R3 R5", {tag, " data"}, {dq_oe, dq_rise, dq_fall[14:0]},
            {e_oe[s], e_r[s], e_f[s][14:0]});
        // R4 R5: strobe enable and level
        chk(dqs_oe == xoe && dqs_hi == e_oe[s], "R4 R5", {tag, " strobe"},
            {30'd0, dqs_oe, dqs_hi}, {30'd0, xoe, e_oe[s]});
        // R9: end pulse
        chk(burst_end == e_end[s] &&
            (!e_end[s] || (end_bank == e_eb[s] && end_precharged == e_ep[s])),
            "R9", {tag, " end"}, {27'd0, burst_end, end_bank, end_precharged},
            {27'd0, e_end[s], e_eb[s], e_ep[s]});
      end
      cmd_rd = 0;
      for (int i = 0; i < ncmd; i++) begin
        if (c_k[i] == t) begin
          cmd_rd = 1; cmd_bank = 3'(c_bank[i]); cmd_col = 10'(c_col[i]);
          cmd_ap = c_ap[i][0]; cmd_bl8 = c_bl8[i][0];
        end
      end
    end
    cmd_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_al = 0; cfg_cl = 3; cmd_rd = 0;
    cmd_bank = 0; cmd_col = 0; cmd_ap = 0; cmd_bl8 = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({dq_oe, dqs_oe, dqs_hi, burst_end, end_precharged} == 5'd0 &&
        dq_rise == 16'd0 && dq_fall == 16'd0, "R10", "reset outputs",
        {dq_oe, dqs_oe, dqs_hi, burst_end, dq_rise}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: single BL4 with auto precharge, shortest latency
    ncmd = 0; add_cmd(2, 5, 'h2D, 1, 0);
    run_seg(0, 3, "R1");
    // R3: BL8 column wrap from column 6
    ncmd = 0; add_cmd(2, 3, 'h106, 0, 1); add_cmd(10, 6, 'h3FF, 1, 0);
    run_seg(2, 4, "R3");
    // R6: gapless chains BL4->BL8->BL4
    ncmd = 0; add_cmd(2, 1, 'h10, 0, 0); add_cmd(4, 2, 'h23, 0, 1);
    add_cmd(8, 4, 'h31, 1, 0);
    run_seg(1, 5, "R6");
    // R8: truncation, rejected gap 3, rejected after BL8 with AP
    ncmd = 0; add_cmd(2, 7, 'h45, 0, 1); add_cmd(4, 0, 'h12, 1, 0);
    add_cmd(10, 2, 'h80, 0, 1); add_cmd(13, 3, 'h81, 0, 1);
    add_cmd(20, 4, 'h9C, 1, 1); add_cmd(22, 5, 'h01, 0, 0);
    add_cmd(23, 6, 'h02, 0, 1);
    run_seg(0, 4, "R8");
    // R7: gap 1 after BL4 ignored; gap 3 shares pre/postamble cycle
    ncmd = 0; add_cmd(2, 1, 'h05, 1, 0); add_cmd(3, 2, 'h06, 1, 1);
    add_cmd(5, 3, 'h07, 0, 0); add_cmd(6, 4, 'h08, 0, 0);
    run_seg(3, 3, "R7");
    // R2: clamping at both ends and longest latency
    ncmd = 0; add_cmd(2, 6, 'h3C, 1, 1);
    run_seg(7, 1, "R2");
    ncmd = 0; add_cmd(2, 1, 'h11, 0, 1);
    run_seg(3, 7, "R2");
    ncmd = 0; add_cmd(2, 2, 'h22, 1, 0);
    run_seg(4, 6, "R2");

    // Random segments
    for (int sgi = 0; sgi < 8; sgi++) begin
      int k;
      ncmd = 0; k = 2;
      for (int i = 0; i < 6; i++) begin
        if (i > 0) k += 1 + int'($urandom % 5);
        add_cmd(k, int'($urandom % 8), int'($urandom % 1024),
                int'($urandom % 2), int'($urandom % 2));
      end
      run_seg(int'($urandom % 6), 2 + int'($urandom % 6), "random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule